// File: doc/BRIEF.md
# TDM Time-Slot Assigner with Shadow Routing Table

This block walks a time-division-multiplexed frame under the control of a routing table that sits in on-chip RAM. The RAM is split into four equal banks. Each table entry names a destination channel, a run length of one to eight units, whether each unit is one bit or one byte, a set of strobe outputs to raise, and whether it closes the frame. On every serial bit time the assigner reports which destination owns that bit and gives a one-cycle valid pulse. It holds the chosen strobes high for as long as the entry lasts.

Software loads the table through a simple write port and sets the enable input only after the table has been written. The RAM is not cleared at reset. Software picks a starting bank for the active table. It may also pick a later bank as the start of a shadow copy. With a shadow copy in use, software rewrites the idle copy and then raises a change request. At the next frame sync the two copies trade places and the pending flag drops. Writes aimed at the copy being walked are refused while the block runs, and the refusal is recorded.

The serial bit clock comes in as a bit-time enable, `bitTick`, in the system clock domain. A frame sync is only recognised in a cycle where `bitTick` is high, and that bit time is the first bit of the new frame.

Top module: `slot_assigner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `chanValid`, `strobeOut`, `chanSel`, `chgPending`, `wrErr` and `syncOvr` are all zero.
- R2: While `enable` is low no bit time is routed: `chanValid` stays low and `strobeOut` stays zero, even when `bitTick` and `frameSync` are high.
- R3: Entry word layout: bits [3:0] give the destination, [6:4] give the run length minus one, bit 7 set means byte units, bits [11:8] give the strobe mask, and bit 15 marks the last entry. Bits [14:12] are reserved. On a bit time that carries `frameSync`, entry 0 of the active region is used. In the cycle after that clock edge, `chanSel` shows its destination, `strobeOut` shows its mask and `chanValid` is high for one cycle.
- R4: An entry in bit units covers exactly (run length) bit times, and then the walk moves on to the next entry.
- R5: An entry in byte units covers exactly 8 × (run length) bit times.
- R6: `strobeOut` holds the entry's mask through every bit time of that entry. It is zero after any bit time that is not routed.
- R7: Once the final bit time of an entry with the last flag has passed, later bit times give no valid pulse and zero strobes until the next frame sync.
- R8: `chanValid` only pulses in the cycle after a clock edge where `bitTick` was high. Between bit times `chanSel` keeps its value.
- R9: A `chgReq` pulse sets `chgPending`. The next frame sync with a shadow bank configured swaps the regions and clears `chgPending`, and that frame is routed from the former shadow region. The active region starts at bank `startBank`. The shadow region starts at bank `shadowBank`, which must be greater than `startBank`. Each region holds min(shadowBank−startBank, 4−shadowBank) banks of 64 entries.
- R10: While `enable` is high, a write whose address falls in the active region leaves the table unchanged and sets the sticky `wrErr` flag. A write to the shadow region is accepted.
- R11: A frame sync that arrives before the walk reaches its last entry restarts the walk at entry 0 and sets the sticky `syncOvr` flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable, set after the table is loaded |
| startBank | input | 2 | First bank of the primary region |
| shadowEn | input | 1 | Use a shadow region |
| shadowBank | input | 2 | First bank of the shadow region |
| bitTick | input | 1 | One-cycle marker of a serial bit time |
| frameSync | input | 1 | Frame start, qualified by bitTick |
| chgReq | input | 1 | Request a region swap at the next frame sync |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 8 | Table write address (bank × 64 + index) |
| wrData | input | 16 | Table entry to write |
| chanSel | output | 4 | Destination of the current bit time |
| chanValid | output | 1 | One-cycle pulse per routed bit time |
| strobeOut | output | 4 | Strobes of the current entry |
| chgPending | output | 1 | Swap request not yet taken |
| wrErr | output | 1 | Sticky: a write to the active region was refused |
| syncOvr | output | 1 | Sticky: frame sync arrived mid-walk |

## Verification
Every routed result is registered once. The destination, strobes and valid pulse for a bit time therefore appear in the cycle after the clock edge that sampled `bitTick`. The swap, the clearing of `chgPending` and the overrun flag all land on that same edge. A refused write raises `wrErr` one cycle after the edge that sampled `wrEn`. The bench drives every input on the falling edge and holds it for exactly one rising edge. It samples on the next falling edge, so each check reads the value that was due one register stage after its stimulus.

// File: rtl/slot_assigner_pkg.sv
package slot_assigner_pkg;
  localparam int CHAN_W    = 4;
  localparam int STROBE_W  = 4;
  localparam int RUN_W     = 3;
  localparam int ENTRY_W   = 16;

  typedef struct packed {
    logic                 last;
    logic [2:0]           rsvd;
    logic [STROBE_W-1:0]  strobes;
    logic                 byteMode;
    logic [RUN_W-1:0]     lenM1;
    logic [CHAN_W-1:0]    dest;
  } route_entry_t;

  typedef struct packed {
    logic emit;       // route the current bit time
    logic blank;      // bit time with nothing to route
    logic useShadow;  // region selection for this read
    logic swapped;    // registered region selection
  } route_ctrl_t;
endpackage

// File: rtl/slot_assigner_datapath.sv
module slot_assigner_datapath
  import slot_assigner_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 64,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int DEPTH_W   = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + DEPTH_W,
  localparam int ENTRIES   = NUM_BANKS * BANK_DEPTH
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [BANK_W-1:0]   startBank,
  input  logic                shadowEn,
  input  logic [BANK_W-1:0]   shadowBank,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ENTRY_W-1:0]  wrData,
  input  route_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0]   rdPtr,
  output logic                entLast,
  output logic                entByte,
  output logic [RUN_W-1:0]    entLenM1,
  output logic [ADDR_W:0]     limit,
  output logic                shadowOk,
  output logic [CHAN_W-1:0]   chanSel,
  output logic                chanValid,
  output logic [STROBE_W-1:0] strobeOut,
  output logic                wrErr
);
  logic [ENTRY_W-1:0] mem [ENTRIES];
  logic [BANK_W:0]    sizeBanks;
  logic [BANK_W:0]    gapBanks;
  logic [BANK_W:0]    tailBanks;
  logic [BANK_W-1:0]  readBank;
  logic [BANK_W-1:0]  heldBank;
  logic [ADDR_W:0]    heldBase;
  logic [ADDR_W-1:0]  rdAddr;
  logic               inActive;
  logic               wrAccept;
  route_entry_t       rdEntry;

  assign shadowOk  = shadowEn && (shadowBank > startBank);
  assign gapBanks  = {1'b0, shadowBank} - {1'b0, startBank};
  assign tailBanks = (BANK_W+1)'(NUM_BANKS) - {1'b0, shadowBank};
  assign sizeBanks = !shadowOk ? (BANK_W+1)'(NUM_BANKS) - {1'b0, startBank}
                   : (gapBanks < tailBanks) ? gapBanks : tailBanks;
  assign limit     = {sizeBanks, {DEPTH_W{1'b0}}};

  assign readBank  = (shadowOk && ctrl.useShadow) ? shadowBank : startBank;
  assign rdAddr    = {readBank, {DEPTH_W{1'b0}}} + rdPtr;
  assign rdEntry   = route_entry_t'(mem[rdAddr]);
  assign entLast   = rdEntry.last;
  assign entByte   = rdEntry.byteMode;
  assign entLenM1  = rdEntry.lenM1;

  assign heldBank  = (shadowOk && ctrl.swapped) ? shadowBank : startBank;
  assign heldBase  = {1'b0, heldBank, {DEPTH_W{1'b0}}};
  assign inActive  = ({1'b0, wrAddr} >= heldBase) && ({1'b0, wrAddr} < heldBase + limit);
  assign wrAccept  = wrEn && !(enable && inActive);

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel   <= '0;
      chanValid <= 1'b0;
      strobeOut <= '0;
      wrErr     <= 1'b0;
    end else begin
      if (wrEn && enable && inActive) wrErr <= 1'b1;
      if (!enable) begin
        chanValid <= 1'b0;
        strobeOut <= '0;
      end else if (ctrl.emit) begin
        chanSel   <= rdEntry.dest;
        strobeOut <= rdEntry.strobes;
        chanValid <= 1'b1;
      end else begin
        chanValid <= 1'b0;
        if (ctrl.blank) strobeOut <= '0;
      end
    end
  end
endmodule

// File: rtl/slot_assigner_control.sv
module slot_assigner_control
  import slot_assigner_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitTick,
  input  logic              frameSync,
  input  logic              chgReq,
  input  logic              shadowOk,
  input  logic              entLast,
  input  logic              entByte,
  input  logic [RUN_W-1:0]  entLenM1,
  input  logic [ADDR_W:0]   limit,
  output route_ctrl_t       ctrl,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              chgPending,
  output logic              syncOvr
);
  logic              running;
  logic              swapped;
  logic [ADDR_W-1:0] ptr;
  logic [2:0]        bitCnt;
  logic [RUN_W-1:0]  unitCnt;
  logic              tickSync;
  logic              swapNow;
  logic              emit;
  logic [2:0]        curBit;
  logic [RUN_W-1:0]  curUnit;
  logic              unitDone;
  logic              entryDone;
  logic              endWalk;

  assign tickSync = enable && bitTick && frameSync;
  assign swapNow  = tickSync && chgPending && shadowOk;
  assign emit     = tickSync || (enable && bitTick && running);
  assign rdPtr    = tickSync ? '0 : ptr;
  assign curBit   = tickSync ? '0 : bitCnt;
  assign curUnit  = tickSync ? '0 : unitCnt;

  assign unitDone  = !entByte || (curBit == 3'd7);
  assign entryDone = unitDone && (curUnit == entLenM1);
  assign endWalk   = entryDone && (entLast || ({1'b0, rdPtr} == limit - 1'b1));

  assign ctrl.emit      = emit;
  assign ctrl.blank     = enable && bitTick && !emit;
  assign ctrl.useShadow = swapped ^ swapNow;
  assign ctrl.swapped   = swapped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      swapped    <= 1'b0;
      ptr        <= '0;
      bitCnt     <= '0;
      unitCnt    <= '0;
      chgPending <= 1'b0;
      syncOvr    <= 1'b0;
    end else begin
      if (swapNow) begin
        swapped    <= !swapped;
        chgPending <= 1'b0;
      end else if (chgReq) begin
        chgPending <= 1'b1;
      end
      if (tickSync && running) syncOvr <= 1'b1;
      if (!enable) begin
        running <= 1'b0;
      end else if (emit) begin
        if (entryDone) begin
          bitCnt  <= '0;
          unitCnt <= '0;
          ptr     <= rdPtr + 1'b1;
          running <= !endWalk;
        end else if (unitDone) begin
          bitCnt  <= '0;
          unitCnt <= curUnit + 1'b1;
          ptr     <= rdPtr;
          running <= 1'b1;
        end else begin
          bitCnt  <= curBit + 1'b1;
          unitCnt <= curUnit;
          ptr     <= rdPtr;
          running <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slot_assigner.sv
module slot_assigner
  import slot_assigner_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 64,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = BANK_W + $clog2(BANK_DEPTH)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [BANK_W-1:0]   startBank,
  input  logic                shadowEn,
  input  logic [BANK_W-1:0]   shadowBank,
  input  logic                bitTick,
  input  logic                frameSync,
  input  logic                chgReq,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ENTRY_W-1:0]  wrData,
  output logic [CHAN_W-1:0]   chanSel,
  output logic                chanValid,
  output logic [STROBE_W-1:0] strobeOut,
  output logic                chgPending,
  output logic                wrErr,
  output logic                syncOvr
);
  route_ctrl_t        ctrl;
  logic [ADDR_W-1:0]  rdPtr;
  logic               entLast;
  logic               entByte;
  logic [RUN_W-1:0]   entLenM1;
  logic [ADDR_W:0]    limit;
  logic               shadowOk;

  slot_assigner_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .frameSync(frameSync), .chgReq(chgReq), .shadowOk(shadowOk),
    .entLast(entLast), .entByte(entByte), .entLenM1(entLenM1),
    .limit(limit), .ctrl(ctrl), .rdPtr(rdPtr),
    .chgPending(chgPending), .syncOvr(syncOvr)
  );

  slot_assigner_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .startBank(startBank),
    .shadowEn(shadowEn), .shadowBank(shadowBank), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ctrl(ctrl), .rdPtr(rdPtr),
    .entLast(entLast), .entByte(entByte), .entLenM1(entLenM1),
    .limit(limit), .shadowOk(shadowOk), .chanSel(chanSel),
    .chanValid(chanValid), .strobeOut(strobeOut), .wrErr(wrErr)
  );
endmodule

// File: rtl/slot_assigner_chk.sv
module slot_assigner_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       bitTick,
  input logic       frameSync,
  input logic       chanValid,
  input logic [3:0] strobeOut,
  input logic       chgPending,
  input logic       wrErr,
  input logic       syncOvr
);
  AST_VALID_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |-> $past(enable));                                            // R2
  AST_VALID_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |-> $past(bitTick));                                           // R8
  AST_IDLE_STROBES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!chanValid && $past(bitTick)) |-> (strobeOut == 4'd0));                 // R6
  AST_SWAP_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chgPending) |-> $past(frameSync && bitTick && enable));            // R9
  AST_WRERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrErr) |-> wrErr);                                                 // R10
  AST_SYNCOVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(syncOvr) |-> syncOvr);                                             // R11
endmodule

bind slot_assigner slot_assigner_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
  .frameSync(frameSync), .chanValid(chanValid), .strobeOut(strobeOut),
  .chgPending(chgPending), .wrErr(wrErr), .syncOvr(syncOvr)
);

// File: tb/sim_slot_assigner.sv
module sim_slot_assigner;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [1:0]  startBank;
  logic        shadowEn;
  logic [1:0]  shadowBank;
  logic        bitTick;
  logic        frameSync;
  logic        chgReq;
  logic        wrEn;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;
  logic [3:0]  chanSel;
  logic        chanValid;
  logic [3:0]  strobeOut;
  logic        chgPending;
  logic        wrErr;
  logic        syncOvr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  slot_assigner u0 (.*);

  function automatic logic [15:0] mkEntry(input logic [3:0] dest, input int len,
      input logic byteMode, input logic [3:0] strb, input logic last);
    logic [2:0] lm1;
    lm1 = 3'(len - 1);
    return {last, 3'b000, strb, byteMode, lm1, dest};
  endfunction

  task automatic check(input string req, input int actual, input int expected, input string what);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic writeEntry(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one bit time: drive at negedge, edge, sample at following negedge
  task automatic bitTime(input logic sync);
    @(negedge clk);
    bitTick = 1'b1; frameSync = sync;
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0;
  endtask

  task automatic expectBit(input string req, input logic v, input logic [3:0] ch, input logic [3:0] st);
    check(req, int'(chanValid), int'(v), "chanValid");
    if (v) check(req, int'(chanSel), int'(ch), "chanSel");
    check(req, int'(strobeOut), int'(st), "strobeOut");
  endtask

  task automatic testReset();
    rstN = 1'b0; enable = 1'b0; startBank = 2'd0; shadowEn = 1'b1; shadowBank = 2'd2;
    bitTick = 1'b0; frameSync = 1'b0; chgReq = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R1", int'({chanValid, strobeOut, chanSel, chgPending, wrErr, syncOvr}), 0, "outputs in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'({chanValid, strobeOut, chanSel, chgPending, wrErr, syncOvr}), 0, "outputs after reset");
  endtask

  task automatic testLoadDisabled();
    writeEntry(8'd0,   mkEntry(4'd3, 2, 1'b0, 4'b0001, 1'b0));
    writeEntry(8'd1,   mkEntry(4'd5, 1, 1'b1, 4'b0010, 1'b1));
    writeEntry(8'd128, mkEntry(4'd9, 1, 1'b0, 4'b1000, 1'b1));
    bitTime(1'b1);
    expectBit("R2", 1'b0, 4'd0, 4'd0);
    check("R2", int'(syncOvr), 0, "no overrun while disabled");
  endtask

  task automatic testFrameWalk();
    enable = 1'b1;
    bitTime(1'b1);
    expectBit("R3", 1'b1, 4'd3, 4'b0001);
    @(negedge clk);
    check("R8", int'(chanValid), 0, "valid single pulse");
    check("R8", int'(chanSel), 3, "chanSel held between ticks");
    bitTime(1'b0);
    expectBit("R4", 1'b1, 4'd3, 4'b0001);
    for (int i = 0; i < 8; i++) begin
      bitTime(1'b0);
      expectBit("R5", 1'b1, 4'd5, 4'b0010);
    end
    bitTime(1'b0);
    expectBit("R7", 1'b0, 4'd0, 4'd0);
    bitTime(1'b0);
    expectBit("R7", 1'b0, 4'd0, 4'd0);
    check("R11", int'(syncOvr), 0, "no overrun on clean frame");
  endtask

  task automatic testWriteProtect();
    writeEntry(8'd0, mkEntry(4'd12, 1, 1'b0, 4'b0100, 1'b1));
    check("R10", int'(wrErr), 1, "active write flagged");
    writeEntry(8'd128, mkEntry(4'd10, 1, 1'b0, 4'b1000, 1'b1));
    check("R10", int'(wrErr), 1, "flag sticky");
    bitTime(1'b1);
    expectBit("R10", 1'b1, 4'd3, 4'b0001);
  endtask

  task automatic testSwap();
    @(negedge clk); chgReq = 1'b1;
    @(negedge clk); chgReq = 1'b0;
    check("R9", int'(chgPending), 1, "request pending");
    bitTime(1'b1);
    check("R9", int'(chgPending), 0, "request cleared at sync");
    expectBit("R9", 1'b1, 4'd10, 4'b1000);
    bitTime(1'b0);
    expectBit("R7", 1'b0, 4'd0, 4'd0);
  endtask

  task automatic testOverrun();
    @(negedge clk); chgReq = 1'b1;
    @(negedge clk); chgReq = 1'b0;
    bitTime(1'b1);
    expectBit("R9", 1'b1, 4'd3, 4'b0001);
    bitTime(1'b0);
    expectBit("R4", 1'b1, 4'd3, 4'b0001);
    bitTime(1'b1);
    check("R11", int'(syncOvr), 1, "overrun flagged");
    expectBit("R11", 1'b1, 4'd3, 4'b0001);
    bitTime(1'b0);
    expectBit("R11", 1'b1, 4'd3, 4'b0001);
    bitTime(1'b0);
    expectBit("R11", 1'b1, 4'd5, 4'b0010);
  endtask

  task automatic testDisable();
    enable = 1'b0;
    bitTime(1'b0);
    expectBit("R2", 1'b0, 4'd0, 4'd0);
  endtask

  initial begin
    testReset();
    testLoadDisabled();
    testFrameWalk();
    testWriteProtect();
    testSwap();
    testOverrun();
    testDisable();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule